// File: doc/BRIEF.md
# Lane-Replicated Doubleword Shuffle Unit

This datapath block rearranges the 32-bit elements of a vector operand up to 512 bits wide. An 8-bit order control holds four 2-bit selectors. The same four selectors are applied separately inside every 128-bit lane, so an element never leaves its lane. One source element may appear in several destination positions.

The source may be replaced by a broadcast of its low 32 bits. The shuffled result then passes through per-element masking, where a masked-off element either keeps the old destination element or becomes zero. A vector-length select sets how many elements are live. In legacy mode only the low 128 bits are produced and the bits above them keep their old value. In the other modes the bits above the vector length are cleared. When the 4-bit reserved register-specifier field is not all ones outside legacy mode, the block flags an undefined-opcode fault and passes the old destination through unchanged.

A request is accepted when the valid input is high. The result is registered and appears one clock later with an output valid. The block changes no status flags and raises no floating-point exceptions.

Top module: `dword_lane_shuffle`

## Requirements
- R1: For a request without fault or broadcast, destination element 4L+k (lane L, k = 0..3) equals source element 4L+s, where s = order_i[2k+1:2k]. The same selectors apply in every lane. Element j occupies bits [32j+31:32j].
- R2: When mem_src_i=1, bcast_i=1 and legacy_i=0, every source element is replaced by src_i[31:0] before the shuffle. If either flag is 0, the elements are taken from their own positions.
- R3: With mask_en_i=1 and legacy_i=0, a live element j whose mask_i[j] is 1 gets the shuffle result. If mask_i[j] is 0, it gets old_dst_i element j when zero_mode_i=0, and zero when zero_mode_i=1. With mask_en_i=0 every live element gets the shuffle result.
- R4: Outside legacy mode, vlen_i encodes the live element count as 2'b00 = 4, 2'b01 = 8, and 2'b10 or 2'b11 = 16. Every element at or above that count is zero.
- R5: With legacy_i=1, elements 0..3 get the plain shuffle result, and mask, zero mode and broadcast have no effect. dst_o[511:128] equals old_dst_i[511:128], and ud_fault_o is 0 whatever rsvd_spec_i holds.
- R6: With legacy_i=0 and rsvd_spec_i not equal to 4'b1111, ud_fault_o is 1 and dst_o equals old_dst_i.
- R7: valid_o is valid_i delayed by one clock. dst_o and ud_fault_o load only on a clock edge where valid_i is 1, and hold their values otherwise.
- R8: Mask bits at or above the live element count have no effect on dst_o.
- R9: After reset, valid_o, ud_fault_o and dst_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| src_i | input | 512 | Source vector |
| mem_src_i | input | 1 | Source comes from memory |
| bcast_i | input | 1 | Broadcast request |
| order_i | input | 8 | Four 2-bit element selectors |
| vlen_i | input | 2 | Vector length select |
| mask_en_i | input | 1 | Writemask in use |
| mask_i | input | 16 | Per-element writemask |
| zero_mode_i | input | 1 | 1 = zero masked elements, 0 = merge |
| old_dst_i | input | 512 | Previous destination value |
| legacy_i | input | 1 | Legacy 128-bit mode |
| rsvd_spec_i | input | 4 | Reserved register-specifier field |
| valid_o | output | 1 | Result valid |
| dst_o | output | 512 | New destination vector |
| ud_fault_o | output | 1 | Undefined-opcode fault |

## Verification
The hardest case to reach from the ports is the combination of a broadcast source with a partial writemask in merge mode at a short vector length. Masking, the upper-bit clear and the lane replication then all affect the same output word. Uniform random inputs seldom line up the memory and broadcast flags with a valid reserved field and a sparse mask. The bench therefore draws each control with a skewed probability: the reserved field is usually all ones and legacy mode is rare. It also adds directed requests for exactly these combinations, and for mask bits set above the live element count.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    VLEN_128 = 2'b00,
    VLEN_256 = 2'b01,
    VLEN_512 = 2'b10,
    VLEN_512_ALT = 2'b11
  } vlen_e;

  localparam logic [3:0] RSVD_OK = 4'b1111;
endpackage

// File: rtl/dls_src_select.sv
module dls_src_select #(
  parameter int ELEM_W   = 32,
  parameter int NUM_ELEM = 16
) (
  input  logic [ELEM_W*NUM_ELEM-1:0] src_i,
  input  logic                       bcast_en_i,
  output logic [ELEM_W*NUM_ELEM-1:0] elems_o
);
  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_elem
    assign elems_o[j*ELEM_W +: ELEM_W] =
      bcast_en_i ? src_i[ELEM_W-1:0] : src_i[j*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/dls_lane_permute.sv
module dls_lane_permute #(
  parameter int ELEM_W   = 32,
  parameter int LANE_W   = 128,
  parameter int NUM_LANE = 4,
  localparam int PER_LANE = LANE_W / ELEM_W,
  localparam int SEL_W    = $clog2(PER_LANE),
  localparam int ORDER_W  = PER_LANE * SEL_W
) (
  input  logic [LANE_W*NUM_LANE-1:0] elems_i,
  input  logic [ORDER_W-1:0]         order_i,
  output logic [LANE_W*NUM_LANE-1:0] perm_o
);
  for (genvar l = 0; l < NUM_LANE; l++) begin : g_lane
    logic [LANE_W-1:0] lane;
    assign lane = elems_i[l*LANE_W +: LANE_W];
    for (genvar k = 0; k < PER_LANE; k++) begin : g_pos
      logic [SEL_W-1:0] sel;
      assign sel = order_i[k*SEL_W +: SEL_W];
      assign perm_o[l*LANE_W + k*ELEM_W +: ELEM_W] = lane[sel*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/dls_mask_merge.sv
module dls_mask_merge #(
  parameter int ELEM_W   = 32,
  parameter int NUM_ELEM = 16
) (
  input  logic [ELEM_W*NUM_ELEM-1:0] perm_i,
  input  logic [ELEM_W*NUM_ELEM-1:0] old_i,
  input  logic [NUM_ELEM-1:0]        live_i,
  input  logic [NUM_ELEM-1:0]        mask_i,
  input  logic                       mask_on_i,
  input  logic                       zero_mode_i,
  input  logic                       keep_upper_i,
  output logic [ELEM_W*NUM_ELEM-1:0] res_o
);
  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_elem
    logic [ELEM_W-1:0] p, o, r;
    assign p = perm_i[j*ELEM_W +: ELEM_W];
    assign o = old_i[j*ELEM_W +: ELEM_W];
    always_comb begin
      if (!live_i[j])                    r = keep_upper_i ? o : '0;
      else if (mask_on_i && !mask_i[j])  r = zero_mode_i ? '0 : o;
      else                               r = p;
    end
    assign res_o[j*ELEM_W +: ELEM_W] = r;
  end
endmodule

// File: rtl/dword_lane_shuffle.sv
module dword_lane_shuffle
  import dls_pkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int LANE_W   = 128,
  parameter int NUM_LANE = 4,
  localparam int VEC_W    = LANE_W * NUM_LANE,
  localparam int PER_LANE = LANE_W / ELEM_W,
  localparam int NUM_ELEM = PER_LANE * NUM_LANE,
  localparam int ORDER_W  = PER_LANE * $clog2(PER_LANE)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [VEC_W-1:0]    src_i,
  input  logic                mem_src_i,
  input  logic                bcast_i,
  input  logic [ORDER_W-1:0]  order_i,
  input  logic [1:0]          vlen_i,
  input  logic                mask_en_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic                zero_mode_i,
  input  logic [VEC_W-1:0]    old_dst_i,
  input  logic                legacy_i,
  input  logic [3:0]          rsvd_spec_i,
  output logic                valid_o,
  output logic [VEC_W-1:0]    dst_o,
  output logic                ud_fault_o
);
  logic [VEC_W-1:0]    elems, perm, merged;
  logic [NUM_ELEM-1:0] live;
  logic                fault, bcast_en;
  int unsigned         live_cnt;

  assign fault    = !legacy_i && (rsvd_spec_i != RSVD_OK);
  assign bcast_en = mem_src_i && bcast_i && !legacy_i;

  always_comb begin
    if (legacy_i) live_cnt = PER_LANE;
    else begin
      unique case (vlen_e'(vlen_i))
        VLEN_128: live_cnt = PER_LANE;
        VLEN_256: live_cnt = 2 * PER_LANE;
        default:  live_cnt = NUM_ELEM;
      endcase
    end
  end

  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_live
    assign live[j] = (j < live_cnt);
  end

  dls_src_select #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_src (
    .src_i(src_i), .bcast_en_i(bcast_en), .elems_o(elems)
  );

  dls_lane_permute #(.ELEM_W(ELEM_W), .LANE_W(LANE_W), .NUM_LANE(NUM_LANE)) u_perm (
    .elems_i(elems), .order_i(order_i), .perm_o(perm)
  );

  dls_mask_merge #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_mask (
    .perm_i(perm), .old_i(old_dst_i), .live_i(live), .mask_i(mask_i),
    .mask_on_i(mask_en_i && !legacy_i), .zero_mode_i(zero_mode_i),
    .keep_upper_i(legacy_i), .res_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      dst_o      <= '0;
      ud_fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o      <= fault ? old_dst_i : merged;
        ud_fault_o <= fault;
      end
    end
  end
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       mask_i,
  input logic             mask_en_i,
  input logic             zero_mode_i,
  input logic [1:0]       vlen_i,
  input logic [VEC_W-1:0] old_dst_i,
  input logic             legacy_i,
  input logic [3:0]       rsvd_spec_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] dst_o,
  input logic             ud_fault_o
);
  logic ok_req;
  assign ok_req = valid_i && !legacy_i && rsvd_spec_i == 4'b1111;

  assert_valid_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dst_o) && $stable(ud_fault_o)));
  assert_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legacy_i && rsvd_spec_i != 4'b1111) |=>
      (ud_fault_o && dst_o == $past(old_dst_i)));
  assert_legacy_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legacy_i) |=>
      (!ud_fault_o && dst_o[VEC_W-1:LANE_W] == $past(old_dst_i[VEC_W-1:LANE_W])));
  assert_upper_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_req && vlen_i == 2'b00) |=> (dst_o[VEC_W-1:LANE_W] == '0));
  assert_zero_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_req && mask_en_i && zero_mode_i && mask_i == 4'h0) |=>
      (dst_o[LANE_W-1:0] == '0));
endmodule

bind dword_lane_shuffle dls_checker #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mask_i(mask_i[3:0]),
  .mask_en_i(mask_en_i), .zero_mode_i(zero_mode_i), .vlen_i(vlen_i),
  .old_dst_i(old_dst_i), .legacy_i(legacy_i), .rsvd_spec_i(rsvd_spec_i),
  .valid_o(valid_o), .dst_o(dst_o), .ud_fault_o(ud_fault_o)
);

// File: tb/tb_dword_lane_shuffle.sv
module tb_dword_lane_shuffle;
  localparam int CLK_P = 10;

  logic         clk_i = 0, rst_ni = 0, valid_i = 0;
  logic [511:0] src_i = '0, old_dst_i = '0;
  logic         mem_src_i = 0, bcast_i = 0, mask_en_i = 0, zero_mode_i = 0, legacy_i = 0;
  logic [7:0]   order_i = '0;
  logic [1:0]   vlen_i = '0;
  logic [15:0]  mask_i = '0;
  logic [3:0]   rsvd_spec_i = 4'hF;
  logic         valid_o, ud_fault_o;
  logic [511:0] dst_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dword_lane_shuffle dut (.*);

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] model();
    logic [511:0] r;
    int cnt;
    if (!legacy_i && rsvd_spec_i != 4'hF) return old_dst_i;
    cnt = legacy_i ? 4 : (vlen_i == 2'd0 ? 4 : vlen_i == 2'd1 ? 8 : 16);
    for (int j = 0; j < 16; j++) begin
      int sel;
      logic [31:0] s, o;
      sel = order_i[(j%4)*2 +: 2];
      s = (mem_src_i && bcast_i && !legacy_i) ? src_i[31:0] : src_i[((j/4)*4+sel)*32 +: 32];
      o = old_dst_i[j*32 +: 32];
      if (j >= cnt) r[j*32 +: 32] = legacy_i ? o : 32'h0;
      else if (!legacy_i && mask_en_i && !mask_i[j]) r[j*32 +: 32] = zero_mode_i ? 32'h0 : o;
      else r[j*32 +: 32] = s;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one request, check output one clock later
  task automatic op(string tag);
    logic [511:0] e;
    logic ef;
    @(negedge clk_i);
    valid_i = 1;
    e = model();
    ef = !legacy_i && rsvd_spec_i != 4'hF;
    @(negedge clk_i);
    valid_i = 0;
    chk(tag, dst_o, e);
    chk({tag, "_flt"}, {511'b0, ud_fault_o}, {511'b0, ef});
    chk("R7_valid", {511'b0, valid_o}, 512'd1);
  endtask

  task automatic base();
    src_i = rnd512(); old_dst_i = rnd512(); order_i = 8'($urandom);
    mem_src_i = 0; bcast_i = 0; mask_en_i = 0; zero_mode_i = 0; legacy_i = 0;
    vlen_i = 2'd2; mask_i = 16'hFFFF; rsvd_spec_i = 4'hF;
  endtask

  initial begin
    void'($urandom(32'd2024));
    #(CLK_P*3);
    chk("R9_valid", {511'b0, valid_o}, 512'd0);
    chk("R9_dst", dst_o, 512'd0);
    chk("R9_flt", {511'b0, ud_fault_o}, 512'd0);
    @(negedge clk_i); rst_ni = 1;

    base(); order_i = 8'hE4; op("R1_ident");
    base(); order_i = 8'h1B; op("R1_rev");
    base(); order_i = 8'h00; op("R1_dup");
    base(); mem_src_i = 1; bcast_i = 1; order_i = 8'h9C; op("R2_bcast");
    base(); mem_src_i = 0; bcast_i = 1; op("R2_regsrc");
    base(); mask_en_i = 1; mask_i = 16'hA5C3; op("R3_merge");
    base(); mask_en_i = 1; zero_mode_i = 1; mask_i = 16'h3C5A; op("R3_zero");
    base(); mask_en_i = 1; zero_mode_i = 1; mask_i = 16'h0; vlen_i = 2'd0; op("R3_allzero");
    for (int v = 0; v < 4; v++) begin base(); vlen_i = 2'(v); op("R4_vlen"); end
    base(); legacy_i = 1; mask_en_i = 1; mask_i = 16'h0; zero_mode_i = 1;
    mem_src_i = 1; bcast_i = 1; rsvd_spec_i = 4'h3; op("R5_legacy");
    base(); rsvd_spec_i = 4'h7; op("R6_fault");
    base(); rsvd_spec_i = 4'h0; mask_en_i = 1; op("R6_fault0");
    base(); vlen_i = 2'd1; mask_en_i = 1; mask_i = 16'hFF00 | 16'h5A; op("R8_hi_ign");
    base(); vlen_i = 2'd1; mask_en_i = 1; mask_i = 16'h005A; op("R8_hi_clr");
    base(); vlen_i = 2'd0; mem_src_i = 1; bcast_i = 1; mask_en_i = 1;
    mask_i = 16'hFFF6; op("R8_bcast_mask");

    // hold when idle
    begin
      logic [511:0] held;
      logic hf;
      held = dst_o; hf = ud_fault_o;
      @(negedge clk_i);
      base(); rsvd_spec_i = 4'h1;
      @(negedge clk_i);
      chk("R7_hold", dst_o, held);
      chk("R7_hold_flt", {511'b0, ud_fault_o}, {511'b0, hf});
      chk("R7_idle", {511'b0, valid_o}, 512'd0);
    end

    for (int i = 0; i < 400; i++) begin
      base();
      mem_src_i = 1'($urandom); bcast_i = 1'($urandom);
      mask_en_i = 1'($urandom); zero_mode_i = 1'($urandom);
      mask_i = 16'($urandom); vlen_i = 2'($urandom);
      legacy_i = ($urandom % 8) == 0;
      rsvd_spec_i = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      op("R1_rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule